// File: doc/BRIEF.md
# Read-After-Write Dependency Row Generator

This block builds the dependency graph of one basic block while its instructions stream in, one descriptor per transfer and in program order. A descriptor names a destination register, up to two source registers and three kind flags (memory read, memory write, opcode not recognised). A further flag marks a multiply-style operation that writes the two product registers. For every instruction accepted, the block returns one output row: the instruction's position in the block and a bit vector with bit k set when that instruction must wait for instruction k. A row of all zeros is a node with no predecessor.

Register hazards are tracked with a table that holds, per register, the position of its latest writer. Only true data flow creates edges; reuse of a name by a later writer never does. Memory operations are ordered conservatively because their addresses are not known. Every memory read waits for all earlier memory writes. Every memory write waits for all earlier memory reads and writes. The descriptor carrying the end-of-block flag closes the block: all tables clear, numbering restarts at zero, and a one-cycle completion pulse follows once that last row has been taken.

Top module: `raw_dep_gen`

## Requirements
- R1: When a source operand names a register written by an earlier instruction of the same block, the row has the bit of the most recent such writer set; both operands naming the same writer give a single bit.
- R2: Write-after-read and write-after-write reuse of a register never sets a bit: an earlier writer that a later writer has replaced is not reported.
- R3: Register 0 reads as constant: reading it sets no bit, and writing it records no writer.
- R4: Register numbers 32 (low product) and 33 (high product) are ordinary tracked registers; a descriptor with `in_wr_hilo` set records itself as the writer of both.
- R5: A descriptor with `in_load` set gets a bit for every earlier instruction of the block that had `in_store` set, whatever its registers.
- R6: A descriptor with `in_store` set gets a bit for every earlier instruction of the block that had `in_load` or `in_store` set.
- R7: A descriptor with `in_unknown` set gets an all-zero row, and no later row has its bit set, whatever its other fields.
- R8: Every accepted descriptor produces exactly one row; a row with no predecessors is emitted all zeros and carries its own index.
- R9: Indices count 0, 1, 2, ... in arrival order; the descriptor with `in_last` set ends the block, after which indices restart at 0 and no row refers to an instruction of an earlier block.
- R10: `in_ready` is high whenever no row is pending or the pending row is taken in the same cycle; an accepted descriptor's row appears on the output the next cycle, and a row not taken holds its index, bits and last flag unchanged.
- R11: `done` pulses high for exactly one cycle, the cycle after the row carrying `out_last` is taken.
- R12: With the default `MAX_N` of 32, a block of 32 descriptors is handled in full, bit 31 of the row being the last position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Descriptor can be accepted |
| in_dst | input | 6 | Destination register number |
| in_dst_en | input | 1 | Destination field is used |
| in_src0 | input | 6 | First source register number |
| in_src0_en | input | 1 | First source is used |
| in_src1 | input | 6 | Second source register number |
| in_src1_en | input | 1 | Second source is used |
| in_wr_hilo | input | 1 | Writes both product registers (32 and 33) |
| in_load | input | 1 | Reads memory |
| in_store | input | 1 | Writes memory |
| in_unknown | input | 1 | Opcode not recognised |
| in_last | input | 1 | Final descriptor of the block |
| out_valid | output | 1 | Row present |
| out_ready | input | 1 | Consumer takes the row |
| out_idx | output | 5 | Position of the instruction in the block |
| out_row | output | 32 | Predecessor bit vector, bit k is instruction k |
| out_last | output | 1 | Row belongs to the final descriptor |
| done | output | 1 | One-cycle pulse after the final row is taken |

## Verification
The hardest situation to reach is a register whose latest writer differs from an older one, combined with memory edges and an unrecognised instruction in between, so that a stale writer, a missing memory bit or a leak from the unknown entry each shows as a wrong bit. The stimulus builds a block where one register is written twice around a read, a memory write follows reads, and an unknown descriptor with store and destination flags sits between a load and its consumer. A second hard point is a descriptor held at the input while the output is stalled; the bench drops `out_ready`, offers the next descriptor, and checks that the pending row stays frozen until the consumer returns.

// File: rtl/raw_dep_pkg.sv
// Package raw_dep_pkg
// Shared constants for the dependency row generator: register numbering
// of the general registers and the two product registers.
package raw_dep_pkg;
    localparam int REG_W    = 6;
    localparam int NUM_GPR  = 32;
    localparam int LO_REG   = NUM_GPR;
    localparam int HI_REG   = NUM_GPR + 1;
    localparam int NUM_REGS = NUM_GPR + 2;

    typedef logic [REG_W-1:0] reg_num_t;
endpackage

// File: rtl/raw_writer_table.sv
// Module raw_writer_table
// Holds, per tracked register, the index of its most recent writer in the
// current block plus a valid bit. Two combinational lookup ports.
// Assumes: register 0 is constant (never recorded, never hits); register
// numbers at or above NUM_REGS are never tracked; clear wins over write.
module raw_writer_table
    import raw_dep_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  reg_num_t         wr_reg,
    input  logic             wr_hilo,
    input  logic [IDX_W-1:0] wr_idx,
    input  reg_num_t         rd0_reg,
    output logic             rd0_hit,
    output logic [IDX_W-1:0] rd0_idx,
    input  reg_num_t         rd1_reg,
    output logic             rd1_hit,
    output logic [IDX_W-1:0] rd1_idx
);
    logic [IDX_W-1:0] last_writer [NUM_REGS];
    logic [NUM_REGS-1:0] known;

    // One storage slot per tracked register, each with its own update rule.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_slot
        logic hit_here;
        // Does this accepted write target this slot.
        always_comb begin
            hit_here = 1'b0;
            if (r != 0) begin
                if (wr_en && (int'(wr_reg) == r))
                    hit_here = 1'b1;
                if (wr_hilo && ((r == LO_REG) || (r == HI_REG)))
                    hit_here = 1'b1;
            end
        end

        // Record the newest writer, or forget everything at block end.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                known[r]       <= 1'b0;
                last_writer[r] <= '0;
            end else if (hit_here) begin
                known[r]       <= 1'b1;
                last_writer[r] <= wr_idx;
            end
        end
    end

    // Lookup for the first source operand.
    always_comb begin
        rd0_hit = 1'b0;
        rd0_idx = '0;
        if ((rd0_reg != '0) && (int'(rd0_reg) < NUM_REGS)) begin
            rd0_hit = known[rd0_reg];
            rd0_idx = last_writer[rd0_reg];
        end
    end

    // Lookup for the second source operand.
    always_comb begin
        rd1_hit = 1'b0;
        rd1_idx = '0;
        if ((rd1_reg != '0) && (int'(rd1_reg) < NUM_REGS)) begin
            rd1_hit = known[rd1_reg];
            rd1_idx = last_writer[rd1_reg];
        end
    end
endmodule

// File: rtl/raw_mem_order.sv
// Module raw_mem_order
// Keeps two position masks for the current block: which earlier entries
// read memory and which wrote it. These supply the conservative ordering
// edges. Assumes the index presented never exceeds MAX_N-1.
module raw_mem_order #(
    parameter int MAX_N = 32,
    localparam int IDX_W = $clog2(MAX_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rec_load,
    input  logic             rec_store,
    input  logic [IDX_W-1:0] rec_idx,
    output logic [MAX_N-1:0] load_mask,
    output logic [MAX_N-1:0] store_mask
);
    logic [MAX_N-1:0] pos_onehot;

    // Turn the entry position into its mask bit.
    always_comb begin
        pos_onehot = '0;
        pos_onehot[rec_idx] = 1'b1;
    end

    // Accumulate memory readers and writers, empty at block end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            load_mask  <= '0;
            store_mask <= '0;
        end else begin
            if (rec_load)
                load_mask  <= load_mask | pos_onehot;
            if (rec_store)
                store_mask <= store_mask | pos_onehot;
        end
    end
endmodule

// File: rtl/raw_row_build.sv
// Module raw_row_build
// Combines register lookups and memory masks into one predecessor row.
// Purely combinational. An unrecognised instruction yields an empty row.
// Both operands naming one writer merge into a single bit by construction.
module raw_row_build #(
    parameter int MAX_N = 32,
    localparam int IDX_W = $clog2(MAX_N)
) (
    input  logic             src0_en,
    input  logic             src0_hit,
    input  logic [IDX_W-1:0] src0_idx,
    input  logic             src1_en,
    input  logic             src1_hit,
    input  logic [IDX_W-1:0] src1_idx,
    input  logic             is_load,
    input  logic             is_store,
    input  logic             is_unknown,
    input  logic [MAX_N-1:0] load_mask,
    input  logic [MAX_N-1:0] store_mask,
    output logic [MAX_N-1:0] row
);
    logic [MAX_N-1:0] reg_bits;
    logic [MAX_N-1:0] mem_bits;

    // Register data-flow bits, one per live source operand.
    for (genvar k = 0; k < MAX_N; k++) begin : g_regbit
        assign reg_bits[k] =
            (src0_en && src0_hit && (src0_idx == IDX_W'(k))) ||
            (src1_en && src1_hit && (src1_idx == IDX_W'(k)));
    end

    // Memory ordering bits chosen by the access kind.
    always_comb begin
        mem_bits = '0;
        if (is_load)
            mem_bits = mem_bits | store_mask;
        if (is_store)
            mem_bits = mem_bits | store_mask | load_mask;
    end

    // Final row, suppressed for unrecognised opcodes.
    assign row = is_unknown ? '0 : (reg_bits | mem_bits);
endmodule

// File: rtl/raw_dep_gen.sv
// Module raw_dep_gen (top)
// Streams in one basic block of instruction descriptors, in program order,
// and returns per instruction a row of earlier instructions it depends on.
// Only read-after-write register flow and conservative memory ordering
// create bits. A one-entry output register gives valid/ready flow control.
// Assumes a block never exceeds MAX_N descriptors and ends with in_last.
module raw_dep_gen
    import raw_dep_pkg::*;
#(
    parameter int MAX_N = 32,
    localparam int IDX_W = $clog2(MAX_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [REG_W-1:0] in_dst,
    input  logic             in_dst_en,
    input  logic [REG_W-1:0] in_src0,
    input  logic             in_src0_en,
    input  logic [REG_W-1:0] in_src1,
    input  logic             in_src1_en,
    input  logic             in_wr_hilo,
    input  logic             in_load,
    input  logic             in_store,
    input  logic             in_unknown,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [IDX_W-1:0] out_idx,
    output logic [MAX_N-1:0] out_row,
    output logic             out_last,
    output logic             done
);
    logic             accept;
    logic             known_op;
    logic             block_end;
    logic [IDX_W-1:0] pos;
    logic             s0_hit, s1_hit;
    logic [IDX_W-1:0] s0_idx, s1_idx;
    logic [MAX_N-1:0] ld_mask, st_mask;
    logic [MAX_N-1:0] new_row;

    // Input is taken when the output slot is free or draining now.
    assign in_ready  = !out_valid || out_ready;
    assign accept    = in_valid && in_ready;
    assign known_op  = !in_unknown;
    assign block_end = accept && in_last;

    // Program-order position within the current block.
    always_ff @(posedge clk) begin
        if (!rst_n || block_end)
            pos <= '0;
        else if (accept)
            pos <= pos + 1'b1;
    end

    raw_writer_table #(
        .IDX_W (IDX_W)
    ) u_writers (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (block_end),
        .wr_en   (accept && known_op && in_dst_en),
        .wr_reg  (in_dst),
        .wr_hilo (accept && known_op && in_wr_hilo),
        .wr_idx  (pos),
        .rd0_reg (in_src0),
        .rd0_hit (s0_hit),
        .rd0_idx (s0_idx),
        .rd1_reg (in_src1),
        .rd1_hit (s1_hit),
        .rd1_idx (s1_idx)
    );

    raw_mem_order #(
        .MAX_N (MAX_N)
    ) u_memord (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (block_end),
        .rec_load   (accept && known_op && in_load),
        .rec_store  (accept && known_op && in_store),
        .rec_idx    (pos),
        .load_mask  (ld_mask),
        .store_mask (st_mask)
    );

    raw_row_build #(
        .MAX_N (MAX_N)
    ) u_build (
        .src0_en    (in_src0_en),
        .src0_hit   (s0_hit),
        .src0_idx   (s0_idx),
        .src1_en    (in_src1_en),
        .src1_hit   (s1_hit),
        .src1_idx   (s1_idx),
        .is_load    (in_load),
        .is_store   (in_store),
        .is_unknown (in_unknown),
        .load_mask  (ld_mask),
        .store_mask (st_mask),
        .row        (new_row)
    );

    // Output slot: load on accept, drop when taken, hold while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_row   <= '0;
            out_last  <= 1'b0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_idx   <= pos;
            out_row   <= new_row;
            out_last  <= in_last;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Completion pulse after the closing row leaves.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= out_valid && out_ready && out_last;
    end
endmodule

// File: rtl/raw_dep_gen_chk.sv
// Module raw_dep_gen_chk
// Protocol and ordering properties of raw_dep_gen, bound to every instance.
module raw_dep_gen_chk #(
    parameter int MAX_N = 32,
    localparam int IDX_W = $clog2(MAX_N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_unknown,
    input logic             out_valid,
    input logic             out_ready,
    input logic [IDX_W-1:0] out_idx,
    input logic [MAX_N-1:0] out_row,
    input logic             out_last,
    input logic             done
);
    // R10
    accept_to_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row)
                                       && $stable(out_idx) && $stable(out_last)));

    // R11
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> done);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    backward_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_row >> out_idx) == '0));

    // R7
    unknown_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_unknown) |=> (out_row == '0));
endmodule

bind raw_dep_gen raw_dep_gen_chk #(.MAX_N(MAX_N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_unknown (in_unknown),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_idx    (out_idx),
    .out_row    (out_row),
    .out_last   (out_last),
    .done       (done)
);

// File: tb/raw_dep_gen_test.sv
// Directed bench for raw_dep_gen: one task per scenario.
module raw_dep_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [5:0]  in_dst = '0, in_src0 = '0, in_src1 = '0;
    logic        in_dst_en = 0, in_src0_en = 0, in_src1_en = 0;
    logic        in_wr_hilo = 0, in_load = 0, in_store = 0, in_unknown = 0, in_last = 0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [4:0]  out_idx;
    logic [31:0] out_row;
    logic        out_last;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    raw_dep_gen uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dst(in_dst), .in_dst_en(in_dst_en), .in_src0(in_src0),
        .in_src0_en(in_src0_en), .in_src1(in_src1), .in_src1_en(in_src1_en),
        .in_wr_hilo(in_wr_hilo), .in_load(in_load), .in_store(in_store),
        .in_unknown(in_unknown), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_idx(out_idx), .out_row(out_row),
        .out_last(out_last), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Put one descriptor on the input pins (called at a falling edge).
    task automatic drive(input int dst, input bit de, input int s0, input bit e0,
                         input int s1, input bit e1, input bit hl, input bit ld,
                         input bit st, input bit unk, input bit lst);
        in_dst = 6'(dst); in_dst_en = de;
        in_src0 = 6'(s0); in_src0_en = e0;
        in_src1 = 6'(s1); in_src1_en = e1;
        in_wr_hilo = hl; in_load = ld; in_store = st; in_unknown = unk;
        in_last = lst; in_valid = 1'b1;
    endtask

    // Send one descriptor with out_ready high and check its row.
    task automatic send(input int dst, input bit de, input int s0, input bit e0,
                        input int s1, input bit e1, input bit hl, input bit ld,
                        input bit st, input bit unk, input bit lst,
                        input int exp_idx, input logic [31:0] exp_row,
                        input string req);
        @(negedge clk);
        drive(dst, de, s0, e0, s1, e1, hl, ld, st, unk, lst);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, req, "row valid", 64'(out_valid), 64'd1);
        check(out_idx == 5'(exp_idx), req, "index", 64'(out_idx), 64'(exp_idx));
        check(out_row == exp_row, req, "row bits", 64'(out_row), 64'(exp_row));
        if (lst) begin
            check(out_last == 1'b1, "R9", "last flag", 64'(out_last), 64'd1);
            @(negedge clk);
            check(done == 1'b1, "R11", "done pulse", 64'(done), 64'd1);
            @(negedge clk);
            check(done == 1'b0, "R11", "done width", 64'(done), 64'd0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R10", "reset out_valid", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R10", "reset in_ready", 64'(in_ready), 64'd1);
        check(done == 1'b0, "R11", "reset done", 64'(done), 64'd0);
    endtask

    // Register flow with product registers (32 low, 33 high) and register 0.
    task automatic t_register_flow();
        send(6, 1, 32, 1, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0,   "R8");  // move low
        send(3, 1, 33, 1, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0,   "R8");  // move high
        send(7, 1, 9, 1, 0, 0, 0, 0, 0, 0, 0, 2, 32'h0,    "R8");
        send(0, 0, 6, 1, 7, 1, 1, 0, 0, 0, 0, 3, 32'h5,    "R1");  // multiply
        send(2, 1, 3, 1, 0, 0, 0, 0, 0, 0, 0, 4, 32'h2,    "R1");
        send(5, 1, 32, 1, 0, 0, 0, 0, 0, 0, 0, 5, 32'h8,   "R4");
        send(3, 1, 11, 1, 0, 0, 0, 0, 0, 0, 0, 6, 32'h0,   "R2");
        send(3, 1, 2, 1, 3, 1, 0, 0, 0, 0, 0, 7, 32'h50,   "R1");
        send(2, 1, 3, 1, 5, 1, 0, 0, 0, 0, 0, 8, 32'hA0,   "R2");
        send(0, 0, 2, 1, 0, 1, 0, 0, 0, 0, 1, 9, 32'h100,  "R3");
    endtask

    // Name reuse, duplicate operands, memory ordering and an unknown entry.
    task automatic t_hazards_memory();
        send(4, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0,    "R3");
        send(5, 1, 4, 1, 4, 1, 0, 0, 0, 0, 0, 1, 32'h1,    "R1");
        send(4, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 2, 32'h0,    "R2");
        send(6, 1, 9, 1, 0, 0, 0, 1, 0, 0, 0, 3, 32'h0,    "R5");
        send(0, 0, 5, 1, 4, 1, 0, 0, 1, 0, 0, 4, 32'hE,    "R6");
        send(7, 1, 0, 1, 0, 0, 0, 1, 0, 0, 0, 5, 32'h10,   "R5");
        send(7, 1, 4, 1, 0, 0, 0, 1, 1, 1, 0, 6, 32'h0,    "R7");
        send(8, 1, 7, 1, 0, 0, 0, 0, 0, 0, 0, 7, 32'h20,   "R7");
        send(0, 0, 8, 1, 2, 1, 0, 0, 1, 0, 1, 8, 32'hB8,   "R6");
    endtask

    // New block: no carry-over from the last one; write to register 0 dropped.
    task automatic t_block_restart();
        send(0, 1, 8, 1, 0, 0, 0, 1, 0, 0, 0, 0, 32'h0,    "R9");
        send(9, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0,    "R3");
        send(0, 0, 9, 1, 0, 0, 0, 0, 1, 0, 1, 2, 32'h3,    "R9");
    endtask

    // Output stalled: input must wait, pending row must hold.
    task automatic t_backpressure();
        out_ready = 1'b0;
        @(negedge clk);
        drive(10, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(posedge clk);
        @(negedge clk);
        drive(12, 1, 10, 1, 0, 0, 0, 0, 0, 0, 1);
        check(in_ready == 1'b0, "R10", "in_ready when stalled", 64'(in_ready), 64'd0);
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b1, "R10", "held valid", 64'(out_valid), 64'd1);
        check(out_idx == 5'd0, "R10", "held index", 64'(out_idx), 64'd0);
        check(out_row == 32'h0, "R10", "held row", 64'(out_row), 64'd0);
        check(in_ready == 1'b0, "R10", "still stalled", 64'(in_ready), 64'd0);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_idx == 5'd1, "R10", "next index", 64'(out_idx), 64'd1);
        check(out_row == 32'h1, "R1", "row after stall", 64'(out_row), 64'd1);
        @(negedge clk);
        check(done == 1'b1, "R11", "done after stall", 64'(done), 64'd1);
    endtask

    // Full-size block of memory writes chained through register 1.
    task automatic t_full_block();
        for (int k = 0; k < 32; k++) begin
            logic [63:0] exp;
            exp = (64'd1 << k) - 64'd1;
            send(1, 1, 1, 1, 0, 0, 0, 0, 1, 0, (k == 31), k, 32'(exp), "R12");
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_register_flow();
        t_hazards_memory();
        t_block_restart();
        t_backpressure();
        t_full_block();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule